// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block turns the outcome of a small arithmetic step into the condition bits that later instructions test. A reduced datapath adds, subtracts or shifts left by one position the operand `op_a` (with `op_b` where needed), or passes through a value already shifted elsewhere. The operand width is 8, 16 or 32 bits. From the sized result the block derives sign, zero, nibble carry, odd parity, carry/borrow and signed overflow.

The flags are captured in a 16-bit status word at fixed, non-contiguous positions when the update enable is high. The same word also holds three control bits: string direction, interrupt enable and single-step trap. These are written only through a separate load port. The sized result is presented combinationally. The status word and the individual flag outputs come from the register, one clock after the update.

Top module: `status_flag_unit`

## Requirements
- R1: After an update, the sign flag (word bit 7) equals the most significant bit of the result at the selected operand width.
- R2: After an update, the zero flag (word bit 6) is 1 exactly when the sized result is all zeros.
- R3: After an add or subtract update, the nibble carry flag (word bit 4) is the carry or borrow from bit 3 into bit 4, that is bit 4 of (a XOR b XOR result). For `op_sel` 2 and 3 it is 0.
- R4: After an update, the parity flag (word bit 2) is 1 when the sized result holds an odd number of one bits and 0 when even.
- R5: After an update, the carry flag (word bit 0) is set as follows. For add (`op_sel`=0) it is the carry out of the top bit. For subtract (`op_sel`=1) it is a borrow, meaning a < b unsigned at the width. For a one-bit left shift (`op_sel`=2) it is the top bit of a. For the external shift pass-through (`op_sel`=3) it is `shift_out`.
- R6: After an update, the overflow flag (word bit 11) is signed overflow. For add it is set when a and b have equal top bits and the result top bit differs from a. For subtract it is set when a and b have different top bits and the result top bit differs from a. For the left shift it is the result top bit XOR the carry. For pass-through it is 0.
- R7: Word bits 1, 3, 5 and 12 to 15 always read 0.
- R8: Reset clears the whole word. With `upd_en` low, the arithmetic flag bits (11, 7, 6, 4, 2, 0) keep their value.
- R9: When `ctl_we` is high, word bits 10, 9 and 8 take `ctl_din[2]` (direction), `ctl_din[1]` (interrupt enable) and `ctl_din[0]` (trap) at the next edge, whatever `upd_en` does. Nothing else changes them.
- R10: `result` is the operation result truncated to the width selected by `op_size` (0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits) and zero-extended. Add and subtract wrap, the left shift fills bit 0 with 0, and pass-through returns `op_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand, or pre-shifted value for pass-through |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | 0 add, 1 subtract, 2 shift left by one, 3 pass-through |
| op_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| shift_out | input | 1 | Last bit shifted out by an external shifter |
| upd_en | input | 1 | Capture arithmetic flags at the next edge |
| ctl_we | input | 1 | Load control bits at the next edge |
| ctl_din | input | 3 | {direction, interrupt enable, trap} |
| result | output | 32 | Sized, zero-extended result |
| flags_word | output | 16 | Packed status word |
| ovf_flag | output | 1 | Overflow (bit 11) |
| dir_flag | output | 1 | Direction (bit 10) |
| int_flag | output | 1 | Interrupt enable (bit 9) |
| trap_flag | output | 1 | Trap (bit 8) |
| sign_flag | output | 1 | Sign (bit 7) |
| zero_flag | output | 1 | Zero (bit 6) |
| aux_flag | output | 1 | Nibble carry (bit 4) |
| par_flag | output | 1 | Parity (bit 2) |
| carry_flag | output | 1 | Carry/borrow (bit 0) |

## Verification
A wrong width select or a wrong carry chain shows up in `result` within the same cycle. A wrong flag derivation shows up in `flags_word` one edge after the update. Flags that fail to hold, or control bits written by the arithmetic path, show up as soon as an idle or control-only cycle follows. Random operands at all three widths are mixed with directed boundary values, such as wrap to zero, signed limits, borrow from zero and a set top bit before a shift, so that each flag is seen both set and clear.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

   localparam int FLAG_W  = 16;
   localparam int POS_OVF = 11;
   localparam int POS_DIR = 10;
   localparam int POS_INT = 9;
   localparam int POS_TRP = 8;
   localparam int POS_SGN = 7;
   localparam int POS_ZRO = 6;
   localparam int POS_AUX = 4;
   localparam int POS_PAR = 2;
   localparam int POS_CRY = 0;
   localparam int AUX_BIT = 4;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_SHL = 2'd2,
      OP_EXT = 2'd3
   } op_t;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } arith_flags_t;

   typedef struct packed {
      logic dir;
      logic ien;
      logic trp;
   } ctl_flags_t;

endpackage

// File: rtl/sfu_lane.sv
module sfu_lane
   import sfu_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   input  op_t           op,
   input  logic          shout,
   output logic [LW-1:0] res,
   output arith_flags_t  fl
);
   localparam int TOP = LW - 1;

   if (LW < 8) begin : g_width_chk
      $error("sfu_lane: lane width must be at least 8");
   end

   logic [LW:0] sum_w;
   logic [LW:0] dif_w;
   logic        cry;

   always_comb begin
      sum_w = {1'b0, a} + {1'b0, b};
      dif_w = {1'b0, a} - {1'b0, b};
      unique case (op)
         OP_ADD: begin
            res = sum_w[TOP:0];
            cry = sum_w[LW];
         end
         OP_SUB: begin
            res = dif_w[TOP:0];
            cry = dif_w[LW];
         end
         OP_SHL: begin
            res = {a[TOP-1:0], 1'b0};
            cry = a[TOP];
         end
         default: begin
            res = a;
            cry = shout;
         end
      endcase
   end

   always_comb begin
      fl.cry = cry;
      fl.sgn = res[TOP];
      fl.zro = (res == '0);
      fl.par = ^res;
      fl.aux = 1'b0;
      fl.ovf = 1'b0;
      unique case (op)
         OP_ADD: begin
            fl.aux = a[AUX_BIT] ^ b[AUX_BIT] ^ res[AUX_BIT];
            fl.ovf = (a[TOP] == b[TOP]) && (res[TOP] != a[TOP]);
         end
         OP_SUB: begin
            fl.aux = a[AUX_BIT] ^ b[AUX_BIT] ^ res[AUX_BIT];
            fl.ovf = (a[TOP] != b[TOP]) && (res[TOP] != a[TOP]);
         end
         OP_SHL: begin
            fl.ovf = res[TOP] ^ cry;
         end
         default: begin
            fl.ovf = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg
   import sfu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  arith_flags_t      fl,
   input  logic              ctl_we,
   input  ctl_flags_t        ctl,
   output logic [FLAG_W-1:0] word
);
   logic [FLAG_W-1:0] word_q;
   logic [FLAG_W-1:0] word_d;

   always_comb begin
      word_d = word_q;
      if (upd_en) begin
         word_d[POS_OVF] = fl.ovf;
         word_d[POS_SGN] = fl.sgn;
         word_d[POS_ZRO] = fl.zro;
         word_d[POS_AUX] = fl.aux;
         word_d[POS_PAR] = fl.par;
         word_d[POS_CRY] = fl.cry;
      end
      if (ctl_we) begin
         word_d[POS_DIR] = ctl.dir;
         word_d[POS_INT] = ctl.ien;
         word_d[POS_TRP] = ctl.trp;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign word = word_q;

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
   import sfu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_LANES = 3,
   parameter int SIZE_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        op_sel,
   input  logic [SIZE_W-1:0] op_size,
   input  logic              shift_out,
   input  logic              upd_en,
   input  logic              ctl_we,
   input  logic [2:0]        ctl_din,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags_word,
   output logic              ovf_flag,
   output logic              dir_flag,
   output logic              int_flag,
   output logic              trap_flag,
   output logic              sign_flag,
   output logic              zero_flag,
   output logic              aux_flag,
   output logic              par_flag,
   output logic              carry_flag
);
   localparam int WIDEST = 8 << (NUM_LANES - 1);

   if (DATA_W != WIDEST) begin : g_dw_chk
      $error("status_flag_unit: DATA_W must equal the widest lane");
   end
   if ((1 << SIZE_W) < NUM_LANES) begin : g_sz_chk
      $error("status_flag_unit: SIZE_W too narrow for NUM_LANES");
   end

   op_t               op;
   logic [DATA_W-1:0] lane_res [NUM_LANES];
   arith_flags_t      lane_fl  [NUM_LANES];
   arith_flags_t      sel_fl;
   logic [SIZE_W-1:0] lane_idx;

   assign op = op_t'(op_sel);

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int LW = 8 << i;
      logic [LW-1:0] r;
      sfu_lane #(.LW(LW)) u_lane (
         .a     (op_a[LW-1:0]),
         .b     (op_b[LW-1:0]),
         .op    (op),
         .shout (shift_out),
         .res   (r),
         .fl    (lane_fl[i])
      );
      assign lane_res[i] = DATA_W'(r);
   end

   always_comb begin
      if (int'(op_size) >= NUM_LANES) lane_idx = SIZE_W'(NUM_LANES - 1);
      else                            lane_idx = op_size;
      result = lane_res[lane_idx];
      sel_fl = lane_fl[lane_idx];
   end

   sfu_flag_reg u_freg (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (upd_en),
      .fl     (sel_fl),
      .ctl_we (ctl_we),
      .ctl    (ctl_flags_t'(ctl_din)),
      .word   (flags_word)
   );

   assign ovf_flag   = flags_word[POS_OVF];
   assign dir_flag   = flags_word[POS_DIR];
   assign int_flag   = flags_word[POS_INT];
   assign trap_flag  = flags_word[POS_TRP];
   assign sign_flag  = flags_word[POS_SGN];
   assign zero_flag  = flags_word[POS_ZRO];
   assign aux_flag   = flags_word[POS_AUX];
   assign par_flag   = flags_word[POS_PAR];
   assign carry_flag = flags_word[POS_CRY];

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
   parameter int DATA_W    = 32,
   parameter int NUM_LANES = 3,
   parameter int SIZE_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic              ctl_we,
   input logic [2:0]        ctl_din,
   input logic [SIZE_W-1:0] op_size,
   input logic [DATA_W-1:0] result,
   input logic [15:0]       flags_word
);
   function automatic logic top_bit(logic [DATA_W-1:0] r, logic [SIZE_W-1:0] s);
      int w;
      w = 8 << ((int'(s) >= NUM_LANES) ? NUM_LANES - 1 : int'(s));
      return r[w-1];
   endfunction

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_word[15:12] == 4'd0) && !flags_word[5] && !flags_word[3] && !flags_word[1]); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !ctl_we) |=> $stable(flags_word)); // R8

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (flags_word[10:8] == $past(ctl_din))); // R9

   AST_CTL_NO_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !upd_en) |=> ($stable(flags_word[7:0]) && $stable(flags_word[11]))); // R9

   AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (flags_word[6] == ($past(result) == '0))); // R2

   AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (flags_word[7] == top_bit($past(result), $past(op_size)))); // R1

   AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (flags_word[2] == ^$past(result))); // R4

endmodule

bind status_flag_unit sfu_checker #(
   .DATA_W    (DATA_W),
   .NUM_LANES (NUM_LANES),
   .SIZE_W    (SIZE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_en     (upd_en),
   .ctl_we     (ctl_we),
   .ctl_din    (ctl_din),
   .op_size    (op_size),
   .result     (result),
   .flags_word (flags_word)
);

// File: tb/sim_status_flag_unit.sv
`timescale 1ns/1ps
module sim_status_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [1:0]  op_sel = '0, op_size = '0;
   logic        shift_out = 1'b0, upd_en = 1'b0, ctl_we = 1'b0;
   logic [2:0]  ctl_din = '0;
   logic [31:0] result;
   logic [15:0] flags_word;
   logic ovf_flag, dir_flag, int_flag, trap_flag, sign_flag, zero_flag, aux_flag, par_flag, carry_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [15:0] exp_word = '0;

   always #2.5 clk = ~clk;

   status_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .op_size(op_size), .shift_out(shift_out), .upd_en(upd_en), .ctl_we(ctl_we),
      .ctl_din(ctl_din), .result(result), .flags_word(flags_word),
      .ovf_flag(ovf_flag), .dir_flag(dir_flag), .int_flag(int_flag), .trap_flag(trap_flag),
      .sign_flag(sign_flag), .zero_flag(zero_flag), .aux_flag(aux_flag),
      .par_flag(par_flag), .carry_flag(carry_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int width_of(logic [1:0] s);
      return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
   endfunction

   // model: returns {flag bits at word positions} in [47:32] and result in [31:0]
   function automatic logic [47:0] model(logic [31:0] a, logic [31:0] b, logic [1:0] op,
                                         logic [1:0] s, logic sho);
      int w;
      logic [32:0] msk, am, bm, t, r;
      logic cf, af, of;
      logic [15:0] f;
      w   = width_of(s);
      msk = (33'd1 << w) - 33'd1;
      am  = {1'b0, a} & msk;
      bm  = {1'b0, b} & msk;
      af  = 1'b0;
      of  = 1'b0;
      case (op)
         2'd0: begin
            t = am + bm; r = t & msk; cf = t[w];
            af = am[4] ^ bm[4] ^ r[4];
            of = (am[w-1] == bm[w-1]) && (r[w-1] != am[w-1]);
         end
         2'd1: begin
            r = (am - bm) & msk; cf = (am < bm);
            af = am[4] ^ bm[4] ^ r[4];
            of = (am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]);
         end
         2'd2: begin
            r = (am << 1) & msk; cf = am[w-1];
            of = r[w-1] ^ cf;
         end
         default: begin
            r = am; cf = sho;
         end
      endcase
      f = '0;
      f[11] = of; f[7] = r[w-1]; f[6] = (r == 0); f[4] = af; f[2] = ^r; f[0] = cf;
      return {f, r[31:0]};
   endfunction

   task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                        input logic [1:0] s, input logic sho, input logic ue,
                        input logic cw, input logic [2:0] cd);
      logic [47:0] m;
      @(negedge clk);
      op_a = a; op_b = b; op_sel = op; op_size = s; shift_out = sho;
      upd_en = ue; ctl_we = cw; ctl_din = cd;
      m = model(a, b, op, s, sho);
      #1;
      chk("R10 result", result, m[31:0]);
      if (ue) begin
         exp_word[11] = m[43]; exp_word[7] = m[39]; exp_word[6] = m[38];
         exp_word[4] = m[36]; exp_word[2] = m[34]; exp_word[0] = m[32];
      end
      if (cw) exp_word[10:8] = cd;
      @(posedge clk);
      #1;
      upd_en = 1'b0; ctl_we = 1'b0;
      chk("R1 sign", {31'd0, sign_flag}, {31'd0, exp_word[7]});
      chk("R2 zero", {31'd0, zero_flag}, {31'd0, exp_word[6]});
      chk("R3 aux", {31'd0, aux_flag}, {31'd0, exp_word[4]});
      chk("R4 parity", {31'd0, par_flag}, {31'd0, exp_word[2]});
      chk("R5 carry", {31'd0, carry_flag}, {31'd0, exp_word[0]});
      chk("R6 overflow", {31'd0, ovf_flag}, {31'd0, exp_word[11]});
      chk("R9 control", {29'd0, dir_flag, int_flag, trap_flag}, {29'd0, exp_word[10:8]});
      chk("R7 word", {16'd0, flags_word}, {16'd0, exp_word});
      if (!ue) chk("R8 hold", {26'd0, flags_word[11], flags_word[7:6], flags_word[4],
                               flags_word[2], flags_word[0]},
                   {26'd0, exp_word[11], exp_word[7:6], exp_word[4], exp_word[2], exp_word[0]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset word", {16'd0, flags_word}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      do_op(32'h0000_00FF, 32'h1, 2'd0, 2'd0, 0, 1, 0, 3'b0);   // byte wrap: Z, C, A
      do_op(32'h0000_007F, 32'h1, 2'd0, 2'd0, 0, 1, 0, 3'b0);   // byte signed overflow
      do_op(32'h0000_0000, 32'h1, 2'd1, 2'd1, 0, 1, 0, 3'b0);   // half borrow
      do_op(32'h8000_0000, 32'h1, 2'd1, 2'd2, 0, 1, 0, 3'b0);   // word sub overflow
      do_op(32'h8000_0000, 32'h0, 2'd2, 2'd2, 0, 1, 0, 3'b0);   // shift carry out, zero
      do_op(32'h4000_0000, 32'h0, 2'd2, 2'd3, 0, 1, 0, 3'b0);   // shift overflow, size 3
      do_op(32'h0000_0003, 32'h0, 2'd3, 2'd0, 1, 1, 0, 3'b0);   // pass-through, even parity
      do_op(32'h0000_0007, 32'h0, 2'd3, 2'd0, 0, 1, 0, 3'b0);   // odd parity
      do_op(32'hFFFF_1234, 32'hFFFF_0000, 2'd0, 2'd1, 0, 1, 0, 3'b0); // upper bits dropped
      do_op(32'h1234_5678, 32'h1, 2'd0, 2'd2, 0, 0, 1, 3'b101); // control only
      do_op(32'h0, 32'h0, 2'd0, 2'd2, 0, 1, 1, 3'b010);         // both at once
      do_op(32'hFFFF_FFFF, 32'h1, 2'd0, 2'd2, 0, 0, 0, 3'b111); // idle: hold

      // random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra, rb;
         logic [1:0]  ro, rs;
         ra = $urandom; rb = $urandom;
         if ($urandom_range(0, 3) == 0) rb = ra;
         ro = 2'($urandom_range(0, 3));
         rs = 2'($urandom_range(0, 3));
         do_op(ra, rb, ro, rs, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
               ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule